// File: doc/BRIEF.md
# Streaming 16-point radix-2 delay-feedback FFT

The block computes a 16-point decimation-in-frequency discrete Fourier transform on a continuous stream of complex fixed-point samples. The work is split over four cascaded radix-2 butterfly stages. Each stage keeps its own feedback delay line of 8, 4, 2 and 1 samples. A complex twiddle multiplier follows each of the first three stages. Every butterfly halves its sum and difference, so each result equals the transform divided by 16. Real and imaginary parts are 9-bit two's complement words with 7 fractional bits, so the value range is [-2, 2). Twiddle factors W16^k = exp(-j·2πk/16) are built at elaboration as 10-bit signed words with 8 fractional bits, truncated toward zero. The multiplier products and the halved butterfly outputs are truncated toward minus infinity back to the 9-bit sample word.

Frames are counted from reset. Accepted samples 16f to 16f+15 form frame f, in natural time order. The results of a frame leave in bit-reversed order: output slot j of a frame carries bin k, where k is j with its four bits reversed. So slot 1 carries bin 8 and slot 3 carries bin 12. A frame-start flag marks slot 0.

The pipeline moves as a whole. It advances by one step only when a sample is accepted, which means in_valid and out_ready are both high. in_ready always equals out_ready. out_valid is high only while in_valid is high and the pipeline has taken at least 19 samples since reset. A result is therefore handed over in exactly the same cycle that a new sample is taken. While the pipeline is stalled, all output values hold. The last frame of a burst only drains out as further samples (for example zeros) are pushed in behind it.

Top module: `fft_sdf16`

## Requirements
- R1: After reset, out_valid and out_first are low. out_valid stays low for accepted samples 0 to 18 and is high from accepted sample 19 on. Slot 0 of frame 0 is presented together with accepted sample 19.
- R2: Slot j of frame f is presented with accepted sample 16f+19+j. It carries bin bitrev4(j) of that frame's transform divided by 16. Each part is within 6 LSB of the exact value; for example, an alternating input of +64/-64 LSB gives exactly 64 in slot 1 and 0 in every other slot.
- R3: With every input part within [-1, 1), which means input bits 8 and 7 are equal, no internal twiddle product exceeds the 9-bit output word.
- R4: An impulse of 64 LSB (0.5) at time index 0 gives exactly real 4, imaginary 0 in all 16 slots.
- R5: A constant input of 64 LSB gives exactly 64 in slot 0 and 0 in the other 15 slots, for both parts.
- R6: out_first is high on slot 0 of each frame and low on slots 1 to 15.
- R7: The pipeline advances only when in_valid and out_ready are both high. in_ready equals out_ready. out_valid is low while in_valid is low. Outputs hold while out_ready is low. The results do not depend on the stall pattern.
- R8: Frames sent back to back are transformed independently. Each frame's results depend only on its own 16 samples.
- R9: Word format is 9-bit two's complement with 7 fractional bits. A constant input of real -128 and imaginary 127 gives exactly (-128, 127) in slot 0 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | Sample is taken this cycle if in_valid; mirrors out_ready |
| in_re | input | 9 | Sample real part, 2 integer and 7 fractional bits |
| in_im | input | 9 | Sample imaginary part, same format |
| out_valid | output | 1 | A result is offered (pipeline primed and in_valid high) |
| out_ready | input | 1 | Downstream takes the result; gates the whole pipeline |
| out_re | output | 9 | Result real part, bin value divided by 16 |
| out_im | output | 9 | Result imaginary part, bin value divided by 16 |
| out_first | output | 1 | Result is slot 0 of a frame |

## Verification
The overflow and range properties assume that each input part stays inside [-1, 1). With that bound, the magnitude at any stage is never above √2 of full input scale, so every twiddle product fits the output word. The hold properties assume nothing about the stall pattern. The stimulus keeps all sample parts between -128 and 127 LSB. Random frames are limited to ±100 LSB. Stalls are made by lowering in_valid, out_ready or both in a fixed rotating pattern.

// File: rtl/fft_sdf_pkg.sv
package fft_sdf_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // feedback length of stage s in a transform of 2**lg points
  function automatic int stage_len(input int lg, input int s);
    return 1 << (lg - 1 - s);
  endfunction

  // number of accepted samples between frame start at the input and at stage s
  function automatic int stage_off(input int lg, input int s);
    int acc;
    acc = 0;
    for (int i = 0; i < s; i++) acc += stage_len(lg, i) + 1;
    return acc;
  endfunction

  // total latency from input sample 0 to output slot 0
  function automatic int pipe_lat(input int lg);
    return stage_off(lg, lg);
  endfunction

  // quantized cos(2*pi*k/N), truncated toward zero
  function automatic int tw_re_q(input int lg, input int k, input int frac);
    real ang;
    ang = 2.0 * PI_R * real'(k) / real'(1 << lg);
    return $rtoi($cos(ang) * real'(1 << frac));
  endfunction

  // quantized -sin(2*pi*k/N), truncated toward zero
  function automatic int tw_im_q(input int lg, input int k, input int frac);
    real ang;
    ang = 2.0 * PI_R * real'(k) / real'(1 << lg);
    return $rtoi(-$sin(ang) * real'(1 << frac));
  endfunction

endpackage

// File: rtl/fft_sdf_ctrl.sv
module fft_sdf_ctrl #(
  parameter int CW  = 4,
  parameter int LAT = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          filled
);
  localparam int FW = $clog2(LAT + 1);

  logic [FW-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      fill_q <= '0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
      if (fill_q != FW'(LAT)) fill_q <= fill_q + 1'b1;
    end
  end

  assign filled = (fill_q == FW'(LAT));

  // R1: once primed the pipeline never reports empty again
  assert_fill_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> filled);

endmodule

// File: rtl/fft_sdf_bfly.sv
module fft_sdf_bfly #(
  parameter int DW = 9,
  parameter int L  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 sel,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int EW = DW + 1;

  logic signed [DW-1:0] dl_re [L];
  logic signed [DW-1:0] dl_im [L];
  logic signed [DW-1:0] tail_re, tail_im;
  logic signed [EW-1:0] a_re, a_im, b_re, b_im;
  logic signed [DW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [DW-1:0] push_re, push_im;

  assign tail_re = dl_re[L-1];
  assign tail_im = dl_im[L-1];
  assign a_re    = EW'(tail_re);
  assign a_im    = EW'(tail_im);
  assign b_re    = EW'(x_re);
  assign b_im    = EW'(x_im);

  // halved butterfly, truncated toward minus infinity
  assign sum_re = DW'((a_re + b_re) >>> 1);
  assign sum_im = DW'((a_im + b_im) >>> 1);
  assign dif_re = DW'((a_re - b_re) >>> 1);
  assign dif_im = DW'((a_im - b_im) >>> 1);

  assign y_re    = sel ? sum_re : tail_re;
  assign y_im    = sel ? sum_im : tail_im;
  assign push_re = sel ? dif_re : x_re;
  assign push_im = sel ? dif_im : x_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < L; i++) begin
        dl_re[i] <= '0;
        dl_im[i] <= '0;
      end
    end else if (adv) begin
      dl_re[0] <= push_re;
      dl_im[0] <= push_im;
      for (int i = 1; i < L; i++) begin
        dl_re[i] <= dl_re[i-1];
        dl_im[i] <= dl_im[i-1];
      end
    end
  end

  // R7: a stalled pipeline leaves the feedback line untouched
  assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(tail_re) && $stable(tail_im)));

endmodule

// File: rtl/fft_sdf_twiddle.sv
module fft_sdf_twiddle
  import fft_sdf_pkg::*;
#(
  parameter int DW      = 9,
  parameter int LOG2N   = 4,
  parameter int TW_W    = 10,
  parameter int TW_FRAC = 8,
  parameter int EXPW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic [EXPW-1:0]      ex,
  input  logic signed [DW-1:0] y_re,
  input  logic signed [DW-1:0] y_im,
  output logic signed [DW-1:0] z_re,
  output logic signed [DW-1:0] z_im
);
  localparam int ROMD = 1 << EXPW;
  localparam int PW   = DW + TW_W + 1;
  localparam int HI   = TW_FRAC + DW - 1;

  logic signed [TW_W-1:0] rom_c [ROMD];
  logic signed [TW_W-1:0] rom_s [ROMD];

  genvar k;
  generate
    for (k = 0; k < ROMD; k++) begin : g_rom
      localparam int CV = tw_re_q(LOG2N, k, TW_FRAC);
      localparam int SV = tw_im_q(LOG2N, k, TW_FRAC);
      assign rom_c[k] = TW_W'(CV);
      assign rom_s[k] = TW_W'(SV);
    end
  endgenerate

  logic signed [PW-1:0] yr_w, yi_w, c_w, s_w, p_re, p_im;

  assign yr_w = PW'(y_re);
  assign yi_w = PW'(y_im);
  assign c_w  = PW'(rom_c[ex]);
  assign s_w  = PW'(rom_s[ex]);

  assign p_re = yr_w * c_w - yi_w * s_w;
  assign p_im = yr_w * s_w + yi_w * c_w;

  // drop fraction bits by truncation toward minus infinity
  assign z_re = DW'(p_re >>> TW_FRAC);
  assign z_im = DW'(p_im >>> TW_FRAC);

  // R3: the kept word carries the full product
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (((&p_re[PW-1:HI]) || !(|p_re[PW-1:HI])) &&
             ((&p_im[PW-1:HI]) || !(|p_im[PW-1:HI]))));

endmodule

// File: rtl/fft_sdf16.sv
module fft_sdf16
  import fft_sdf_pkg::*;
#(
  parameter int DW      = 9,
  parameter int LOG2N   = 4,
  parameter int TW_W    = 10,
  parameter int TW_FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 out_first
);
  localparam int EXPW   = LOG2N - 1;
  localparam int LAT    = pipe_lat(LOG2N);
  localparam int LAST_K = stage_len(LOG2N, LOG2N - 1) + 1;

  logic             adv, filled;
  logic [LOG2N-1:0] cnt, last_k;

  logic signed [DW-1:0] st_in_re [LOG2N];
  logic signed [DW-1:0] st_in_im [LOG2N];
  logic signed [DW-1:0] st_q_re  [LOG2N];
  logic signed [DW-1:0] st_q_im  [LOG2N];

  assign adv      = in_valid && out_ready;
  assign in_ready = out_ready;

  fft_sdf_ctrl #(.CW(LOG2N), .LAT(LAT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .cnt    (cnt),
    .filled (filled)
  );

  assign st_in_re[0] = in_re;
  assign st_in_im[0] = in_im;

  genvar s;
  generate
    for (s = 0; s < LOG2N; s++) begin : g_stage
      localparam int L   = stage_len(LOG2N, s);
      localparam int OFF = stage_off(LOG2N, s);

      logic [LOG2N-1:0]     k_loc;
      logic                 sel;
      logic signed [DW-1:0] y_re, y_im, z_re, z_im, q_re, q_im;

      assign k_loc = cnt - LOG2N'(OFF);
      assign sel   = k_loc[LOG2N-1-s];

      if (s > 0) begin : g_link
        assign st_in_re[s] = st_q_re[s-1];
        assign st_in_im[s] = st_q_im[s-1];
      end

      fft_sdf_bfly #(.DW(DW), .L(L)) u_bf (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .sel   (sel),
        .x_re  (st_in_re[s]),
        .x_im  (st_in_im[s]),
        .y_re  (y_re),
        .y_im  (y_im)
      );

      if (s < LOG2N - 1) begin : g_tw
        logic [EXPW-1:0] ex;
        assign ex = sel ? '0 : EXPW'((k_loc & LOG2N'(L - 1)) << s);

        fft_sdf_twiddle #(
          .DW(DW), .LOG2N(LOG2N), .TW_W(TW_W), .TW_FRAC(TW_FRAC), .EXPW(EXPW)
        ) u_tw (
          .clk   (clk),
          .rst_n (rst_n),
          .adv   (adv),
          .ex    (ex),
          .y_re  (y_re),
          .y_im  (y_im),
          .z_re  (z_re),
          .z_im  (z_im)
        );
      end else begin : g_pass
        assign z_re   = y_re;
        assign z_im   = y_im;
        assign last_k = k_loc;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_re <= '0;
          q_im <= '0;
        end else if (adv) begin
          q_re <= z_re;
          q_im <= z_im;
        end
      end

      assign st_q_re[s] = q_re;
      assign st_q_im[s] = q_im;
    end
  endgenerate

  assign out_re    = st_q_re[LOG2N-1];
  assign out_im    = st_q_im[LOG2N-1];
  assign out_valid = filled && in_valid;
  assign out_first = out_valid && (last_k == LOG2N'(LAST_K));

  // R3: input contract, both parts inside [-1, 1)
  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((in_re[DW-1] == in_re[DW-2]) && (in_im[DW-1] == in_im[DW-2])));

  // R7: an offered result that is not taken holds its value
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_re) && $stable(out_im)));

  // R6: a frame start is followed by a slot that is not a frame start
  assert_first_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first && adv) |=> !out_first);

endmodule

// File: tb/fft_sdf16_test.sv
module fft_sdf16_test;

  localparam int DW  = 9;
  localparam int NP  = 16;
  localparam int LAT = 19;
  localparam int TOL = 6;
  localparam real PI_T = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic in_ready, out_valid, out_first;
  logic signed [DW-1:0] out_re, out_im;

  fft_sdf16 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_first(out_first)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int nacc = 0;
  bit finished = 1'b0;
  bit [31:0] seed = 32'h1234_5678;

  int  ib_re [0:1023];
  int  ib_im [0:1023];
  int  ob_re [0:1023];
  int  ob_im [0:1023];
  bit  ob_v  [0:1023];
  bit  ob_f  [0:1023];
  int  fr_re [NP];
  int  fr_im [NP];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 32'd201) - 100;
  endfunction

  function automatic int bitrev(input int v);
    int r;
    r = 0;
    for (int b = 0; b < 4; b++) if (v[b]) r |= (1 << (3 - b));
    return r;
  endfunction

  // mode 0: no sample offered; 1: downstream not ready; 2: both low
  task automatic push(input int re, input int im, input int nst, input int mode);
    bit held;
    int h_re, h_im;
    held = 1'b0;
    h_re = 0;
    h_im = 0;
    for (int i = 0; i < nst; i++) begin
      @(negedge clk);
      in_valid  = (mode == 1);
      out_ready = (mode == 0);
      in_re = DW'(re);
      in_im = DW'(im);
      #1;
      chk(in_ready == out_ready, "R7 in_ready", int'(in_ready), int'(out_ready));
      if (!in_valid) chk(!out_valid, "R7 valid without sample", int'(out_valid), 0);
      else if (out_valid) begin
        if (held) chk(int'(out_re) == h_re && int'(out_im) == h_im, "R7 stall hold",
                      int'(out_re), h_re);
        held = 1'b1;
        h_re = int'(out_re);
        h_im = int'(out_im);
      end
    end
    @(negedge clk);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    in_re = DW'(re);
    in_im = DW'(im);
    #1;
    if (held && out_valid)
      chk(int'(out_re) == h_re && int'(out_im) == h_im, "R7 held value taken",
          int'(out_re), h_re);
    ib_re[nacc] = re;
    ib_im[nacc] = im;
    ob_v[nacc]  = out_valid;
    ob_f[nacc]  = out_first;
    ob_re[nacc] = int'(out_re);
    ob_im[nacc] = int'(out_im);
    nacc++;
    @(posedge clk);
  endtask

  task automatic push_frame();
    for (int n = 0; n < NP; n++) push(fr_re[n], fr_im[n], 0, 0);
  endtask

  task automatic flush();
    for (int n = 0; n < 2 * NP; n++) push(0, 0, 0, 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_marks(input int f);
    for (int j = 0; j < NP; j++) begin
      int t;
      t = NP * f + LAT + j;
      chk(ob_v[t], "R2 result valid", int'(ob_v[t]), 1);
      chk(ob_f[t] == (j == 0), "R6 frame start flag", int'(ob_f[t]), int'(j == 0));
    end
  endtask

  task automatic check_exact(input int f, input int j, input int er, input int ei,
                             input string req);
    int t;
    t = NP * f + LAT + j;
    chk(ob_re[t] == er, req, ob_re[t], er);
    chk(ob_im[t] == ei, req, ob_im[t], ei);
  endtask

  task automatic check_tol(input int f, input string req);
    check_marks(f);
    for (int j = 0; j < NP; j++) begin
      int t, k;
      real xr, xi, ang;
      t = NP * f + LAT + j;
      k = bitrev(j);
      xr = 0.0;
      xi = 0.0;
      for (int n = 0; n < NP; n++) begin
        ang = 2.0 * PI_T * real'(k * n) / real'(NP);
        xr += real'(ib_re[NP*f+n]) * $cos(ang) + real'(ib_im[NP*f+n]) * $sin(ang);
        xi += real'(ib_im[NP*f+n]) * $cos(ang) - real'(ib_re[NP*f+n]) * $sin(ang);
      end
      xr = xr / real'(NP);
      xi = xi / real'(NP);
      chk((real'(ob_re[t]) - xr) <= real'(TOL) && (xr - real'(ob_re[t])) <= real'(TOL),
          req, ob_re[t], $rtoi(xr));
      chk((real'(ob_im[t]) - xi) <= real'(TOL) && (xi - real'(ob_im[t])) <= real'(TOL),
          req, ob_im[t], $rtoi(xi));
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    @(negedge clk);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    #1;
    chk(!out_valid, "R1 reset valid", int'(out_valid), 0);
    chk(!out_first, "R1 reset first", int'(out_first), 0);
    chk(in_ready, "R7 ready at reset", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic test_impulse();
    int f;
    f = nacc / NP;
    for (int n = 0; n < NP; n++) begin
      fr_re[n] = (n == 0) ? 64 : 0;
      fr_im[n] = 0;
    end
    push_frame();
    flush();
    for (int t = 0; t <= LAT; t++)
      chk(ob_v[t] == (t >= LAT), "R1 fill latency", int'(ob_v[t]), int'(t >= LAT));
    check_marks(f);
    for (int j = 0; j < NP; j++) check_exact(f, j, 4, 0, "R4 impulse");
  endtask

  task automatic test_dc();
    int f;
    f = nacc / NP;
    for (int n = 0; n < NP; n++) begin
      fr_re[n] = 64;
      fr_im[n] = 0;
    end
    push_frame();
    flush();
    check_marks(f);
    for (int j = 0; j < NP; j++) check_exact(f, j, (j == 0) ? 64 : 0, 0, "R5 constant");
  endtask

  task automatic test_alternate();
    int f;
    f = nacc / NP;
    for (int n = 0; n < NP; n++) begin
      fr_re[n] = (n % 2 == 0) ? 64 : -64;
      fr_im[n] = 0;
    end
    push_frame();
    flush();
    for (int j = 0; j < NP; j++) check_exact(f, j, (j == 1) ? 64 : 0, 0, "R2 bin 8 in slot 1");
  endtask

  task automatic test_full_scale();
    int f;
    f = nacc / NP;
    for (int n = 0; n < NP; n++) begin
      fr_re[n] = -128;
      fr_im[n] = 127;
    end
    push_frame();
    flush();
    for (int j = 0; j < NP; j++)
      check_exact(f, j, (j == 0) ? -128 : 0, (j == 0) ? 127 : 0, "R9 full scale");
  endtask

  task automatic test_tone();
    int f;
    f = nacc / NP;
    for (int n = 0; n < NP; n++) begin
      fr_re[n] = $rtoi(96.0 * $cos(2.0 * PI_T * real'(3 * n) / real'(NP)));
      fr_im[n] = 0;
    end
    push_frame();
    flush();
    check_tol(f, "R2 tone");
  endtask

  task automatic test_back_to_back();
    int f;
    f = nacc / NP;
    for (int r = 0; r < 2; r++) begin
      for (int n = 0; n < NP; n++) begin
        fr_re[n] = rnd();
        fr_im[n] = rnd();
      end
      push_frame();
    end
    flush();
    check_tol(f, "R8 first of pair");
    check_tol(f + 1, "R8 second of pair");
  endtask

  task automatic test_stall();
    int f;
    f = nacc / NP;
    for (int n = 0; n < NP; n++) push(rnd(), rnd(), (n % 4) + 1, n % 3);
    for (int n = 0; n < 2 * NP; n++) push(0, 0, n % 2, (n + 1) % 3);
    @(negedge clk);
    in_valid = 1'b0;
    check_tol(f, "R7 stalled frame");
  endtask

  initial begin
    test_reset();
    test_impulse();
    test_dc();
    test_alternate();
    test_full_scale();
    test_tone();
    test_back_to_back();
    test_stall();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", nacc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule